// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is a first-in first-out buffer that joins two unrelated clock domains. The producer pushes words on the write clock and the consumer pulls them on the read clock. The words sit in an internal array whose depth is a power of two set by a parameter. The read side ends in an output register. The level on a mode input is captured while master reset is held, and it picks one of two output behaviours. In standard mode a word moves into the output register only on a read request. In fall-through mode the oldest word is placed on the output with no request, and the output register counts as one more storage slot.

Each domain keeps a binary pointer and publishes a Gray-coded copy. The other domain samples that copy through a two-flop synchroniser. Flags that concern space are computed on the write side. Flags that concern data are computed on the read side. The block drives a half-full flag, an almost-full flag and an almost-empty flag. The thresholds of the last two come from offset registers that an external loader fills through a load strobe. Master reset clears the block, restores the default offsets and captures the mode again. Partial reset clears only the data. A retransmit strobe returns the read side to the first array location, so the words written since the last reset are replayed.

Top module: `ftfifo_top`

## Requirements
- R1: While `mrst_n` is low, the block captures `mode_sel` (0 = standard, 1 = fall-through). In standard mode, `wflag` low means full and `rflag` low means empty. In fall-through mode, `wflag` high means no space, and `rflag` low means a valid word is on `dout`.
- R2: In standard mode, a read with `ren` high and data stored puts the oldest word on `dout` at the next `rclk` edge. Words come out in write order.
- R3: In fall-through mode, the oldest word appears on `dout` with no read request. A read with `ren` high replaces it with the next word, or sets `rflag` high when nothing is left.
- R4: With no reads after reset, standard mode accepts 2^AW writes and fall-through mode accepts 2^AW+1 writes before `wflag` reports no space.
- R5: A write while no space is reported is ignored, and so is a read while empty. The pointers and `dout` stay unchanged, and the refused word is never read out.
- R6: `paf_n` goes low once the array holds at least 2^AW − m words, where m is the almost-full offset. In standard mode with no reads this happens after 2^AW − m writes. In fall-through mode it happens after 2^AW − m + 1 writes.
- R7: `pae_n` is low while the stored word count is at most n, where n is the almost-empty offset. In fall-through mode the count includes the output register.
- R8: `hf_n` is low while the array holds more than 2^AW/2 words.
- R9: Master reset empties the block, sets both offsets to `DEF_AE` and `DEF_AF`, and captures the mode again.
- R10: Partial reset empties the block but keeps the loaded offsets and the mode. `mode_sel` is ignored during partial reset.
- R11: A one-cycle `rt` pulse moves the read side back to array location 0. In fall-through mode, `rflag` is high in the cycle after the pulse, and one cycle later the first written word is on `dout` with `rflag` low.
- R12: The first-word latency is fixed, counted in read-clock edges after the `wclk` edge that takes a write into an empty block. In standard mode `rflag` rises at the second `rclk` edge. In fall-through mode the word and a low `rflag` appear at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, held for several cycles of both clocks |
| prst_n | input | 1 | Partial reset, active low, held for several cycles of both clocks |
| mode_sel | input | 1 | Output mode, captured during master reset |
| wen | input | 1 | Write request |
| din | input | DW | Write data |
| ofs_ld | input | 1 | Loads both offset registers (write clock) |
| ae_ofs | input | AW | Almost-empty offset to load |
| af_ofs | input | AW | Almost-full offset to load |
| ren | input | 1 | Read request |
| rt | input | 1 | Retransmit strobe (read clock) |
| dout | output | DW | Output register |
| wflag | output | 1 | Full (standard, low active) or no-space (fall-through, high active) |
| rflag | output | 1 | Empty (standard, low active) or not-ready (fall-through, high active) |
| hf_n | output | 1 | Half-full, active low |
| paf_n | output | 1 | Almost-full, active low |
| pae_n | output | 1 | Almost-empty, active low |

## Verification
The properties assume the following about the inputs. Each reset is held long enough to flush both synchronisers. Offsets are loaded only while the block is idle, because the read side uses the almost-empty offset without synchronising it. A retransmit is raised only after at least two and at most 2^AW writes since the last reset, and only while the write side is idle, so the jump of the read pointer crosses domains without a write racing it. The stimulus meets these conditions: it waits several cycles after every reset, offset load and burst, and it starts a retransmit only after the writes have settled.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } mode_e;
endpackage

// File: rtl/ftf_sync.sv
module ftf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (clr_i) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/ftf_mem.sv
module ftf_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ftf_wside.sv
module ftf_wside
    import ftf_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DEF_AE = 3,
    parameter int DEF_AF = 3
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel_i,
    input  logic          wen_i,
    input  logic          ofs_ld_i,
    input  logic [AW-1:0] ae_ofs_i,
    input  logic [AW-1:0] af_ofs_i,
    input  logic [AW:0]   rgray_s_i,
    output logic          we_o,
    output logic [AW:0]   wbin_o,
    output logic [AW:0]   wgray_o,
    output logic          mode_o,
    output logic [AW-1:0] ae_ofs_o,
    output logic          wflag_o,
    output logic          hf_n_o,
    output logic          paf_n_o
);
    localparam logic [AW:0] DEPTH_W = (AW+1)'(1 << AW);
    localparam logic [AW:0] HALF_W  = (AW+1)'(1 << (AW-1));

    typedef struct packed {
        logic [AW:0]   wbin;
        logic [AW:0]   wgray;
        mode_e         mode;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
    } wst_t;

    wst_t        d, q;
    logic [AW:0] rbin_s;
    logic [AW:0] used;
    logic        full;

    always_comb begin
        for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s_i >> i);
        used = q.wbin - rbin_s;
        full = (used == DEPTH_W);
        we_o = wen_i & ~full & mrst_n & prst_n;
        d    = q;
        if (!mrst_n) begin
            d.wbin = '0;
            d.mode = mode_e'(mode_sel_i);
            d.ae   = AW'(DEF_AE);
            d.af   = AW'(DEF_AF);
        end else if (!prst_n) begin
            d.wbin = '0;
        end else begin
            if (we_o) d.wbin = q.wbin + 1'b1;
            if (ofs_ld_i) begin
                d.ae = ae_ofs_i;
                d.af = af_ofs_i;
            end
        end
        d.wgray = d.wbin ^ (d.wbin >> 1);
    end

    always_ff @(posedge clk) q <= d;

    assign wbin_o   = q.wbin;
    assign wgray_o  = q.wgray;
    assign mode_o   = q.mode;
    assign ae_ofs_o = q.ae;
    assign wflag_o  = (q.mode == MODE_FWFT) ? full : ~full;
    assign hf_n_o   = ~(used > HALF_W);
    assign paf_n_o  = ~(used >= (DEPTH_W - {1'b0, q.af}));
endmodule

// File: rtl/ftf_rside.sv
module ftf_rside
    import ftf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel_i,
    input  logic          ren_i,
    input  logic          rt_i,
    input  logic [AW:0]   wgray_s_i,
    input  logic [AW-1:0] ae_ofs_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW:0]   rbin_o,
    output logic [AW:0]   rgray_o,
    output logic          mode_o,
    output logic [DW-1:0] dout_o,
    output logic          rflag_o,
    output logic          pae_n_o
);
    typedef struct packed {
        logic [AW:0]   rbin;
        logic [AW:0]   rgray;
        logic [DW-1:0] dout;
        logic          ov;
        mode_e         mode;
    } rst_t;

    rst_t        d, q;
    logic [AW:0] wbin_s;
    logic [AW:0] level;
    logic        empty;
    logic        ft;

    always_comb begin
        for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s_i >> i);
        empty = (wbin_s == q.rbin);
        ft    = (q.mode == MODE_FWFT);
        level = (wbin_s - q.rbin) + {{AW{1'b0}}, ft & q.ov};
        d     = q;
        if (!mrst_n) begin
            d.rbin = '0;
            d.dout = '0;
            d.ov   = 1'b0;
            d.mode = mode_e'(mode_sel_i);
        end else if (!prst_n) begin
            d.rbin = '0;
            d.dout = '0;
            d.ov   = 1'b0;
        end else if (rt_i) begin
            d.rbin = '0;
            d.ov   = 1'b0;
        end else if (ft) begin
            if (!empty && (!q.ov || ren_i)) begin
                d.dout = rdata_i;
                d.rbin = q.rbin + 1'b1;
                d.ov   = 1'b1;
            end else if (ren_i) begin
                d.ov = 1'b0;
            end
        end else if (ren_i && !empty) begin
            d.dout = rdata_i;
            d.rbin = q.rbin + 1'b1;
        end
        d.rgray = d.rbin ^ (d.rbin >> 1);
    end

    always_ff @(posedge clk) q <= d;

    assign rbin_o  = q.rbin;
    assign rgray_o = q.rgray;
    assign mode_o  = q.mode;
    assign dout_o  = q.dout;
    assign rflag_o = ft ? ~q.ov : ~empty;
    assign pae_n_o = ~(level <= {1'b0, ae_ofs_i});
endmodule

// File: rtl/ftfifo_top.sv
module ftfifo_top #(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int DEF_AE = 3,
    parameter int DEF_AF = 3
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          wen,
    input  logic [DW-1:0] din,
    input  logic          ofs_ld,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    input  logic          ren,
    input  logic          rt,
    output logic [DW-1:0] dout,
    output logic          wflag,
    output logic          rflag,
    output logic          hf_n,
    output logic          paf_n,
    output logic          pae_n
);
    logic [AW:0]   wptr_bin, wptr_gray, wgray_sync;
    logic [AW:0]   rptr_bin, rptr_gray, rgray_sync;
    logic [AW-1:0] ae_cur;
    logic [DW-1:0] rdata;
    logic          we;
    logic          wmode, rmode;
    logic          sync_clr;

    assign sync_clr = ~mrst_n | ~prst_n;

    ftf_sync #(.W(AW+1)) u_r2w (
        .clk(wclk), .clr_i(sync_clr), .d_i(rptr_gray), .q_o(rgray_sync)
    );

    ftf_sync #(.W(AW+1)) u_w2r (
        .clk(rclk), .clr_i(sync_clr), .d_i(wptr_gray), .q_o(wgray_sync)
    );

    ftf_wside #(.AW(AW), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_w (
        .clk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel_i(mode_sel),
        .wen_i(wen), .ofs_ld_i(ofs_ld), .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs),
        .rgray_s_i(rgray_sync), .we_o(we), .wbin_o(wptr_bin), .wgray_o(wptr_gray),
        .mode_o(wmode), .ae_ofs_o(ae_cur), .wflag_o(wflag), .hf_n_o(hf_n),
        .paf_n_o(paf_n)
    );

    ftf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .we_i(we), .waddr_i(wptr_bin[AW-1:0]), .wdata_i(din),
        .raddr_i(rptr_bin[AW-1:0]), .rdata_o(rdata)
    );

    ftf_rside #(.DW(DW), .AW(AW)) u_r (
        .clk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel_i(mode_sel),
        .ren_i(ren), .rt_i(rt), .wgray_s_i(wgray_sync), .ae_ofs_i(ae_cur),
        .rdata_i(rdata), .rbin_o(rptr_bin), .rgray_o(rptr_gray), .mode_o(rmode),
        .dout_o(dout), .rflag_o(rflag), .pae_n_o(pae_n)
    );
endmodule

// File: rtl/ftfifo_chk.sv
module ftfifo_chk #(
    parameter int AW = 4
) (
    input logic        wclk,
    input logic        rclk,
    input logic        mrst_n,
    input logic        prst_n,
    input logic        wen,
    input logic        ren,
    input logic        rt,
    input logic        wflag,
    input logic        rflag,
    input logic        hf_n,
    input logic        paf_n,
    input logic        pae_n,
    input logic        wmode,
    input logic        rmode,
    input logic [AW:0] wptr_bin,
    input logic [AW:0] rptr_bin
);
    logic in_rst;
    logic no_space;
    assign in_rst   = ~mrst_n | ~prst_n;
    assign no_space = wmode ? wflag : ~wflag;

    a_r5_no_write_when_full: assert property (@(posedge wclk) disable iff (in_rst)
        (wen && no_space) |=> $stable(wptr_bin));

    a_r5_no_read_when_empty: assert property (@(posedge rclk) disable iff (in_rst)
        (ren && !rt && !rmode && !rflag) |=> $stable(rptr_bin));

    a_r4_wptr_single_step: assert property (@(posedge wclk) disable iff (in_rst)
        (wptr_bin == $past(wptr_bin)) || (wptr_bin == (AW+1)'($past(wptr_bin) + 1'b1)));

    a_r8_full_sets_level_flags: assert property (@(posedge wclk) disable iff (in_rst)
        no_space |-> (!hf_n && !paf_n));

    a_r7_empty_sets_pae: assert property (@(posedge rclk) disable iff (in_rst)
        (!rmode && !rflag) |-> !pae_n);

    a_r11_rt_drops_ready: assert property (@(posedge rclk) disable iff (in_rst)
        (rmode && rt) |=> rflag);
endmodule

bind ftfifo_top ftfifo_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_ftfifo_top.sv
module sim_ftfifo_top;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int DAE = 3;
    localparam int DAF = 3;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
    logic          wen = 1'b0, ofs_ld = 1'b0, ren = 1'b0, rt = 1'b0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
    logic [DW-1:0] dout;
    logic          wflag, rflag, hf_n, paf_n, pae_n;

    int            n_chk = 0, n_bad = 0;
    bit            ft = 1'b0;
    logic [DW-1:0] sb[$];

    always #4 wclk = ~wclk;
    initial begin
        #3;
        forever #4 rclk = ~rclk;
    end

    ftfifo_top #(.DW(DW), .AW(AW), .DEF_AE(DAE), .DEF_AF(DAF)) u0 (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .wen(wen), .din(din), .ofs_ld(ofs_ld),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ren(ren), .rt(rt), .dout(dout),
        .wflag(wflag), .rflag(rflag), .hf_n(hf_n), .paf_n(paf_n), .pae_n(pae_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
    endtask

    // driver: pushes the word the design should keep
    task automatic wr(input logic [DW-1:0] v);
        @(negedge wclk);
        wen = 1'b1;
        din = v;
        @(negedge wclk);
        wen = 1'b0;
        if (sb.size() < (ft ? DEPTH + 1 : DEPTH)) sb.push_back(v);
    endtask

    // monitor for standard mode: pops and compares
    task automatic rd_std(input string tag);
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        if (sb.size() > 0) check(tag, dout, sb.pop_front());
    endtask

    // monitor for fall-through mode: head word must already be shown
    task automatic rd_ft(input string tag);
        @(negedge rclk);
        check({tag, " head"}, dout, sb[0]);
        check({tag, " ready"}, rflag, 1'b0);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
        void'(sb.pop_front());
    endtask

    task automatic do_reset(input bit master, input bit m);
        @(negedge wclk);
        mode_sel = m;
        if (master) mrst_n = 1'b0;
        else prst_n = 1'b0;
        repeat (4) @(negedge wclk);
        mrst_n = 1'b1;
        prst_n = 1'b1;
        sb.delete();
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] hold;
        // master reset into standard mode
        repeat (4) @(negedge wclk);
        mrst_n = 1'b1;
        settle();
        check("R9 R1 reset rflag empty", rflag, 1'b0);
        check("R9 R1 reset wflag not full", wflag, 1'b1);
        check("R9 reset hf_n", hf_n, 1'b1);
        check("R9 reset paf_n", paf_n, 1'b1);
        check("R9 reset pae_n", pae_n, 1'b0);

        // R12 standard latency
        @(negedge wclk);
        wen = 1'b1;
        din = 8'hA1;
        @(posedge wclk);
        #1 wen = 1'b0;
        sb.push_back(8'hA1);
        @(posedge rclk);
        #1 check("R12 std rflag after 1st rclk edge", rflag, 1'b0);
        @(posedge rclk);
        #1 check("R12 std rflag after 2nd rclk edge", rflag, 1'b1);
        rd_std("R2 first word");

        // R2 several words in order
        for (int i = 0; i < 5; i++) wr(DW'(8'h30 + i * 7));
        settle();
        for (int i = 0; i < 5; i++) rd_std("R2 ordered read");

        // R4 R6 R8 fill in standard mode
        for (int i = 1; i <= DEPTH; i++) begin
            wr(DW'(8'h50 + i));
            if (i == DEPTH / 2) check("R8 hf_n at half", hf_n, 1'b1);
            if (i == DEPTH / 2 + 1) check("R8 hf_n past half", hf_n, 1'b0);
            if (i == DEPTH - DAF - 1) check("R6 paf_n before threshold", paf_n, 1'b1);
            if (i == DEPTH - DAF) check("R6 paf_n at threshold", paf_n, 1'b0);
            if (i == DEPTH - 1) check("R4 wflag before full", wflag, 1'b1);
            if (i == DEPTH) check("R4 wflag full", wflag, 1'b0);
        end
        wr(8'hEE);
        check("R5 still full after refused write", wflag, 1'b0);
        settle();
        for (int i = DEPTH; i > 0; i--) begin
            rd_std("R5 R2 drain");
            if (i - 1 == DAE + 1) check("R7 pae_n above offset", pae_n, 1'b1);
            if (i - 1 == DAE) check("R7 pae_n at offset", pae_n, 1'b0);
        end
        check("R5 empty after drain", rflag, 1'b0);

        // R5 read while empty
        hold = dout;
        rd_std("R5 unused");
        check("R5 dout stable on empty read", dout, hold);
        check("R5 rflag empty on empty read", rflag, 1'b0);

        // load offsets then partial reset with mode_sel high
        @(negedge wclk);
        ofs_ld = 1'b1;
        ae_ofs = 4'd2;
        af_ofs = 4'd5;
        @(negedge wclk);
        ofs_ld = 1'b0;
        do_reset(1'b0, 1'b1);
        check("R10 mode kept std after partial reset", rflag, 1'b0);
        for (int i = 1; i <= DEPTH - 5; i++) begin
            wr(DW'(8'h70 + i));
            if (i == DEPTH - 6) check("R10 kept af offset below", paf_n, 1'b1);
            if (i == DEPTH - 5) check("R10 kept af offset reached", paf_n, 1'b0);
        end
        settle();
        for (int i = DEPTH - 5; i > 0; i--) begin
            rd_std("R10 drain");
            if (i - 1 == 3) check("R10 kept ae offset above", pae_n, 1'b1);
            if (i - 1 == 2) check("R10 kept ae offset reached", pae_n, 1'b0);
        end

        // master reset into fall-through mode
        do_reset(1'b1, 1'b1);
        ft = 1'b1;
        check("R1 R9 ft rflag not ready", rflag, 1'b1);
        check("R1 R9 ft wflag ready", wflag, 1'b0);
        check("R9 ft pae_n", pae_n, 1'b0);
        check("R9 ft paf_n", paf_n, 1'b1);

        // R12 R3 fall-through latency
        @(negedge wclk);
        wen = 1'b1;
        din = 8'hC0;
        @(posedge wclk);
        #1 wen = 1'b0;
        sb.push_back(8'hC0);
        @(posedge rclk);
        @(posedge rclk);
        #1 check("R12 ft not ready after 2nd edge", rflag, 1'b1);
        @(posedge rclk);
        #1 check("R12 R3 ft ready after 3rd edge", rflag, 1'b0);
        check("R3 ft word shown without read", dout, 8'hC0);
        settle();

        // R4 R6 capacity in fall-through mode
        for (int i = 2; i <= DEPTH + 1; i++) begin
            wr(DW'(8'h80 + i));
            if (i == DEPTH + 1 - DAF - 1) check("R6 ft paf_n before", paf_n, 1'b1);
            if (i == DEPTH + 1 - DAF) check("R6 ft paf_n at", paf_n, 1'b0);
            if (i == DEPTH) check("R4 ft space left", wflag, 1'b0);
            if (i == DEPTH + 1) check("R4 ft no space", wflag, 1'b1);
        end
        wr(8'hEF);
        settle();
        for (int i = 0; i < DEPTH + 1; i++) rd_ft("R3 R5 ft drain");
        @(negedge rclk);
        check("R3 ft not ready after drain", rflag, 1'b1);

        // R10 mode kept, R11 retransmit
        do_reset(1'b0, 1'b0);
        check("R10 ft mode kept", rflag, 1'b1);
        for (int i = 0; i < 4; i++) wr(DW'(8'hD0 + i));
        settle();
        rd_ft("R11 pre read");
        rd_ft("R11 pre read");
        @(negedge rclk);
        rt = 1'b1;
        @(negedge rclk);
        rt = 1'b0;
        check("R11 rflag high after rt", rflag, 1'b1);
        @(negedge rclk);
        check("R11 ready again", rflag, 1'b0);
        check("R11 first word back", dout, 8'hD0);
        sb.delete();
        for (int i = 0; i < 4; i++) sb.push_back(DW'(8'hD0 + i));
        for (int i = 0; i < 4; i++) rd_ft("R11 replay");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule